// File: doc/BRIEF.md
# Multibank Write Expansion Guard

This block sits in the command path of a memory controller. It receives one command at a time (READ, WRITE or refresh) with a 4-bit bank address. It produces a 16-bit mask of the banks that the command touches. A WRITE can be widened to several banks at once, chosen by a two-bit mode field: one bank, two banks 8 apart, or four banks 4 apart. The address bits above the chosen stride are ignored.

Before it accepts a command, the block checks two spacing rules. The first is a sliding-window limit on the number of bank activations. Each bank written by a widened WRITE counts as one activation. The second is a spacing rule around four-bank writes, kept by a small state machine. A command that would break either rule is stalled in that cycle. The requester holds the command until it is accepted. The outputs are combinational in the cycle the command is presented. State updates only when a command is accepted.

The spacing state machine has three states. `SP_OPEN` means no restriction. `SP_AFTER_BANK` means a bank command was accepted recently, so a four-bank WRITE is blocked. `SP_AFTER_QUAD` means a four-bank WRITE was accepted recently, so every bank command is blocked. Its transitions are as follows:
- Any accepted command that is not a four-bank WRITE moves it to `SP_AFTER_BANK`.
- An accepted four-bank WRITE moves it to `SP_AFTER_QUAD`.
- Both hold states return to `SP_OPEN` once `GAP_CYC` cycles have passed since the last accepted command. This is the expiry transition.

Top module: `mbw_guard`

## Requirements
- R1: A READ (op 2'b00) or AREF (op 2'b10) gives a one-hot mask on `cmd_bank`, whatever the mode. A WRITE (op 2'b01) in mode 2'b00, or in the reserved mode 2'b11, also gives a one-hot mask on `cmd_bank`.
- R2: A WRITE in mode 2'b01 sets banks `cmd_bank[2:0]` and `cmd_bank[2:0]+8`. `cmd_bank[3]` has no effect.
- R3: A WRITE in mode 2'b10 sets banks `cmd_bank[1:0]` plus 0, 4, 8 and 12. `cmd_bank[3:2]` have no effect.
- R4: A valid bank command drives exactly one of `cmd_accept` and `cmd_stall`. When `cmd_accept` is low, `bank_en` is zero. An op of 2'b11, or `cmd_valid` low, drives neither flag.
- R5: The activations accepted over the last `WIN_CYC` cycles, counting the current one, never exceed `MAX_ACT`. READ, AREF and a one-bank WRITE count 1, a two-bank WRITE counts 2 and a four-bank WRITE counts 4. A command that fits exactly at the limit is accepted; one that would exceed it is stalled.
- R6: In the cycle right after any accepted bank command, a four-bank WRITE is stalled. It can be accepted `GAP_CYC` (2) cycles after that command.
- R7: In the cycle right after an accepted four-bank WRITE, any bank command is stalled. Bank commands are allowed again `GAP_CYC` cycles after it.
- R8: A stalled command counts toward neither the activation window nor the spacing rule.
- R9: After reset, the window is empty and the spacing machine is in `SP_OPEN`. The first command is accepted whatever its kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | 00 READ, 01 WRITE, 10 AREF, 11 no bank command |
| cmd_bank | input | 4 | Addressed bank |
| wr_mode | input | 2 | 00 one bank, 01 two banks, 10 four banks, 11 reserved (one bank) |
| bank_en | output | 16 | Banks touched by the accepted command |
| cmd_accept | output | 1 | Command accepted in this cycle |
| cmd_stall | output | 1 | Command held back in this cycle by a spacing rule |

## Verification
The assertions assume that `cmd_op`, `cmd_bank` and `wr_mode` are stable and known in the middle of each cycle. They also assume that the mode field does not change while a stalled command is being held, so a held command keeps the same activation count. The bench changes inputs only on the falling clock edge. It samples one time unit later and holds any stalled command unchanged until it is accepted. Idle gaps between scenarios are long enough to empty the activation window and to let the spacing machine return to `SP_OPEN`.

// File: rtl/mbw_pkg.sv
package mbw_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_AREF  = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        WM_ONE  = 2'b00,
        WM_TWO  = 2'b01,
        WM_FOUR = 2'b10,
        WM_RSVD = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        SP_OPEN       = 2'b00,
        SP_AFTER_BANK = 2'b01,
        SP_AFTER_QUAD = 2'b10
    } sp_state_e;

endpackage

// File: rtl/mbw_mask_gen.sv
module mbw_mask_gen
    import mbw_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int CNT_W     = 3,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 is_bank_cmd,
    input  logic [1:0]           op,
    input  logic [BA_W-1:0]      bank,
    input  logic [1:0]           mode,
    output logic [NUM_BANKS-1:0] mask,
    output logic [CNT_W-1:0]     act_cnt,
    output logic                 is_quad
);

    localparam int STRIDE_TWO  = NUM_BANKS / 2;
    localparam int STRIDE_FOUR = NUM_BANKS / 4;

    logic is_write;
    logic want_two;
    logic want_four;

    always_comb begin
        is_write  = is_bank_cmd && (op_e'(op) == OP_WRITE);
        want_two  = is_write && (wmode_e'(mode) == WM_TWO);
        want_four = is_write && (wmode_e'(mode) == WM_FOUR);
        is_quad   = want_four;
        if (!is_bank_cmd)
            act_cnt = '0;
        else if (want_four)
            act_cnt = CNT_W'(4);
        else if (want_two)
            act_cnt = CNT_W'(2);
        else
            act_cnt = CNT_W'(1);
    end

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic hit_one;
        logic hit_two;
        logic hit_four;
        always_comb begin
            hit_one  = (bank == BA_W'(gi));
            hit_two  = ((gi % STRIDE_TWO)  == (int'(bank) % STRIDE_TWO));
            hit_four = ((gi % STRIDE_FOUR) == (int'(bank) % STRIDE_FOUR));
            if (!is_bank_cmd)
                mask[gi] = 1'b0;
            else if (want_four)
                mask[gi] = hit_four;
            else if (want_two)
                mask[gi] = hit_two;
            else
                mask[gi] = hit_one;
        end
    end

    // R3: four-bank expansion sets exactly four banks, one of them the low-bit slot
    always_comb begin
        if (want_four)
            a_r3_four_banks: assert ($countones(mask) == 4 && mask[bank % STRIDE_FOUR]);
    end

    // R2: two-bank expansion sets exactly two banks
    always_comb begin
        if (want_two)
            a_r2_two_banks: assert ($countones(mask) == 2 && mask[bank % STRIDE_TWO]);
    end

    // R1: every other bank command is one-hot on the address
    always_comb begin
        if (is_bank_cmd && !want_two && !want_four)
            a_r1_one_hot: assert ($onehot(mask) && mask[bank]);
    end

endmodule

// File: rtl/mbw_act_window.sv
module mbw_act_window #(
    parameter int WIN_CYC = 8,
    parameter int MAX_ACT = 12,
    parameter int CNT_W   = 3,
    localparam int HIST_N = WIN_CYC - 1,
    localparam int SUM_W  = $clog2(((1 << CNT_W) - 1) * WIN_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] req_cnt,
    input  logic [CNT_W-1:0] took_cnt,
    output logic             fits
);

    logic [CNT_W-1:0] hist [HIST_N];
    logic [SUM_W-1:0] past_sum;
    logic [SUM_W-1:0] total;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST_N; i++)
                hist[i] <= '0;
        end else begin
            hist[0] <= took_cnt;
            for (int i = 1; i < HIST_N; i++)
                hist[i] <= hist[i-1];
        end
    end

    always_comb begin
        past_sum = '0;
        for (int i = 0; i < HIST_N; i++)
            past_sum = past_sum + SUM_W'(hist[i]);
        total = past_sum + SUM_W'(req_cnt);
        fits  = (total <= SUM_W'(MAX_ACT));
    end

    // R5: the history never holds more than the limit
    a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        past_sum <= SUM_W'(MAX_ACT));

    // R8: nothing is taken when the request does not fit
    a_r8_no_take_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !fits |-> took_cnt == '0);

endmodule

// File: rtl/mbw_spacing_fsm.sv
module mbw_spacing_fsm
    import mbw_pkg::*;
#(
    parameter int GAP_CYC = 2,
    localparam int GC_W   = $clog2(GAP_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_quad,
    input  logic took,
    input  logic took_quad,
    output logic allow
);

    sp_state_e        state_q, state_d;
    logic [GC_W-1:0]  left_q,  left_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SP_OPEN;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        if (took) begin
            state_d = took_quad ? SP_AFTER_QUAD : SP_AFTER_BANK;
            left_d  = GC_W'(GAP_CYC - 1);
        end else begin
            unique case (state_q)
                SP_OPEN: begin
                    left_d = '0;
                end
                SP_AFTER_BANK, SP_AFTER_QUAD: begin
                    if (left_q <= GC_W'(1)) begin
                        state_d = SP_OPEN;
                        left_d  = '0;
                    end else begin
                        left_d = left_q - GC_W'(1);
                    end
                end
                default: begin
                    state_d = SP_OPEN;
                    left_d  = '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            SP_OPEN:       allow = 1'b1;
            SP_AFTER_BANK: allow = !req_quad;
            SP_AFTER_QUAD: allow = 1'b0;
            default:       allow = 1'b1;
        endcase
    end

    // R7: nothing is accepted in the cycle after a four-bank write
    a_r7_quad_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        took_quad |=> !took);

    // R6: a four-bank write never follows an accepted command by one cycle
    a_r6_cmd_then_no_quad: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> !took_quad);

endmodule

// File: rtl/mbw_guard.sv
module mbw_guard
    import mbw_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int WIN_CYC   = 8,
    parameter int MAX_ACT   = 12,
    parameter int GAP_CYC   = 2,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int CNT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic [1:0]           wr_mode,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic                 cmd_accept,
    output logic                 cmd_stall
);

    logic                 is_bank_cmd;
    logic [NUM_BANKS-1:0] raw_mask;
    logic [CNT_W-1:0]     req_cnt;
    logic [CNT_W-1:0]     took_cnt;
    logic                 req_quad;
    logic                 win_fits;
    logic                 gap_allow;

    assign is_bank_cmd = cmd_valid && (op_e'(cmd_op) != OP_NONE);

    mbw_mask_gen #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (CNT_W)
    ) u_mask (
        .is_bank_cmd (is_bank_cmd),
        .op          (cmd_op),
        .bank        (cmd_bank),
        .mode        (wr_mode),
        .mask        (raw_mask),
        .act_cnt     (req_cnt),
        .is_quad     (req_quad)
    );

    mbw_act_window #(
        .WIN_CYC (WIN_CYC),
        .MAX_ACT (MAX_ACT),
        .CNT_W   (CNT_W)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_cnt  (req_cnt),
        .took_cnt (took_cnt),
        .fits     (win_fits)
    );

    mbw_spacing_fsm #(
        .GAP_CYC (GAP_CYC)
    ) u_space (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_quad  (req_quad),
        .took      (cmd_accept),
        .took_quad (cmd_accept && req_quad),
        .allow     (gap_allow)
    );

    always_comb begin
        cmd_accept = is_bank_cmd && win_fits && gap_allow;
        cmd_stall  = is_bank_cmd && !cmd_accept;
        bank_en    = cmd_accept ? raw_mask : '0;
        took_cnt   = cmd_accept ? req_cnt : '0;
    end

    // R4: accept and stall are exclusive
    a_r4_accept_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_stall));

    // R4: no bank is enabled without acceptance
    a_r4_mask_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_accept |-> bank_en == '0);

    // R4: a command that is not a bank command raises neither flag
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !is_bank_cmd |-> !cmd_accept && !cmd_stall);

endmodule

// File: tb/test_mbw_guard.sv
`timescale 1ns/100ps
module test_mbw_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [3:0]  cmd_bank;
    logic [1:0]  wr_mode;
    logic [15:0] bank_en;
    logic        cmd_accept;
    logic        cmd_stall;

    int total = 0;
    int bad   = 0;

    localparam logic [1:0] RD = 2'b00, WR = 2'b01, RF = 2'b10, NO = 2'b11;
    localparam logic [1:0] M1 = 2'b00, M2 = 2'b01, M4 = 2'b10, MX = 2'b11;

    always #2.5 clk = ~clk;

    mbw_guard i_mbw_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_bank   (cmd_bank),
        .wr_mode    (wr_mode),
        .bank_en    (bank_en),
        .cmd_accept (cmd_accept),
        .cmd_stall  (cmd_stall)
    );

    task automatic drive(input logic v, input logic [1:0] op, input logic [3:0] b, input logic [1:0] m);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_bank = b; wr_mode = m;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, NO, 4'd0, M1);
    endtask

    task automatic expect_out(input string req, input logic [15:0] m, input logic acc, input logic stl);
        total++;
        if (bank_en !== m || cmd_accept !== acc || cmd_stall !== stl) begin
            bad++;
            $display("FAIL %s: got mask=%h acc=%b stall=%b, expected mask=%h acc=%b stall=%b",
                     req, bank_en, cmd_accept, cmd_stall, m, acc, stl);
        end
    endtask

    task automatic t_reset;
        drive(1'b0, NO, 4'd0, M1);
        expect_out("R9 idle after reset", 16'h0000, 1'b0, 1'b0);
        drive(1'b1, WR, 4'd1, M4);
        expect_out("R9 first quad accepted", 16'h2222, 1'b1, 1'b0);
        idle(8);
    endtask

    task automatic t_single;
        drive(1'b1, WR, 4'd5, M1);
        expect_out("R1 single write", 16'h0020, 1'b1, 1'b0);
        idle(1);
        drive(1'b1, WR, 4'd13, MX);
        expect_out("R1 reserved mode write", 16'h2000, 1'b1, 1'b0);
        idle(1);
        drive(1'b1, RD, 4'd9, M4);
        expect_out("R1 read ignores mode", 16'h0200, 1'b1, 1'b0);
        idle(1);
        drive(1'b1, RF, 4'd0, M2);
        expect_out("R1 aref ignores mode", 16'h0001, 1'b1, 1'b0);
        idle(8);
    endtask

    task automatic t_dual;
        drive(1'b1, WR, 4'd11, M2);
        expect_out("R2 dual bank 11", 16'h0808, 1'b1, 1'b0);
        idle(1);
        drive(1'b1, WR, 4'd3, M2);
        expect_out("R2 dual bank 3 same set", 16'h0808, 1'b1, 1'b0);
        idle(8);
    endtask

    task automatic t_quad;
        drive(1'b1, WR, 4'd14, M4);
        expect_out("R3 quad bank 14", 16'h4444, 1'b1, 1'b0);
        idle(2);
        drive(1'b1, WR, 4'd2, M4);
        expect_out("R3 quad bank 2 same set", 16'h4444, 1'b1, 1'b0);
        idle(8);
    endtask

    task automatic t_nop;
        drive(1'b1, NO, 4'd7, M1);
        expect_out("R4 op 11 is no command", 16'h0000, 1'b0, 1'b0);
        drive(1'b0, RD, 4'd7, M1);
        expect_out("R4 valid low", 16'h0000, 1'b0, 1'b0);
        idle(8);
    endtask

    task automatic t_cmd_then_quad;
        drive(1'b1, RD, 4'd4, M1);
        expect_out("R6 lead read", 16'h0010, 1'b1, 1'b0);
        drive(1'b1, WR, 4'd0, M4);
        expect_out("R6 quad stalled after cmd", 16'h0000, 1'b0, 1'b1);
        drive(1'b1, WR, 4'd0, M4);
        expect_out("R6 quad accepted two later", 16'h1111, 1'b1, 1'b0);
        idle(8);
        drive(1'b1, RD, 4'd4, M1);
        expect_out("R6 lead read again", 16'h0010, 1'b1, 1'b0);
        drive(1'b1, RD, 4'd6, M1);
        expect_out("R6 plain cmd not blocked", 16'h0040, 1'b1, 1'b0);
        idle(8);
    endtask

    task automatic t_quad_then_cmd;
        drive(1'b1, WR, 4'd3, M4);
        expect_out("R7 lead quad", 16'h8888, 1'b1, 1'b0);
        drive(1'b1, RF, 4'd5, M1);
        expect_out("R7 aref stalled after quad", 16'h0000, 1'b0, 1'b1);
        drive(1'b1, RF, 4'd5, M1);
        expect_out("R7 aref accepted two later", 16'h0020, 1'b1, 1'b0);
        idle(8);
    endtask

    task automatic t_stall_no_effect;
        drive(1'b1, RD, 4'd1, M1);
        expect_out("R8 lead read", 16'h0002, 1'b1, 1'b0);
        drive(1'b1, WR, 4'd1, M4);
        expect_out("R8 quad stalled", 16'h0000, 1'b0, 1'b1);
        drive(1'b1, RD, 4'd2, M1);
        expect_out("R8 stalled quad left no guard", 16'h0004, 1'b1, 1'b0);
        idle(8);
    endtask

    task automatic t_window;
        drive(1'b1, WR, 4'd0, M4);
        expect_out("R5 quad 1", 16'h1111, 1'b1, 1'b0);
        idle(1);
        drive(1'b1, WR, 4'd1, M4);
        expect_out("R5 quad 2", 16'h2222, 1'b1, 1'b0);
        idle(1);
        drive(1'b1, WR, 4'd2, M4);
        expect_out("R5 quad 3 at limit", 16'h4444, 1'b1, 1'b0);
        idle(1);
        drive(1'b1, WR, 4'd3, M4);
        expect_out("R5 quad 4 over limit", 16'h0000, 1'b0, 1'b1);
        drive(1'b1, WR, 4'd3, M4);
        expect_out("R5 quad 4 still over", 16'h0000, 1'b0, 1'b1);
        drive(1'b1, WR, 4'd3, M4);
        expect_out("R8 R5 quad 4 fits once oldest leaves", 16'h8888, 1'b1, 1'b0);
        idle(8);
    endtask

    initial begin
        cmd_valid = 1'b0; cmd_op = NO; cmd_bank = 4'd0; wr_mode = M1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_dual();
        t_quad();
        t_nop();
        t_cmd_then_quad();
        t_quad_then_cmd();
        t_stall_no_effect();
        t_window();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #50000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule